// File: doc/BRIEF.md
# Linear CCD Readout Clock Generator

This block produces the continuous readout clocks of a linear CCD from one master clock: two complementary transfer phases, a reset-gate pulse and a clamp pulse. Each clock period is counted in master cycles. The period length, the reset width, the clamp width and the clamp start offset come from runtime inputs. The block samples these inputs once at the start of each period, so a setting that changes mid-period never cuts a pulse short.

A separate integration sequencer stops the clocks through `muteReq`. The block accepts the request only at the last cycle of a period. It then freezes phase 1 high and phase 2 low, holds reset and clamp low, and raises `muted` as the acknowledge. When the request drops, the next cycle starts a fresh period from count zero. `periodStart` marks the first cycle of every period, which lets the sequencer line up with period boundaries.

Top module: `ccd_readout_clkgen`

## Requirements
- R1: `phase2` is always the logical complement of `phase1`.
- R2: While running with latched period P (a `cfgPeriod` below 2 is taken as 2), count c runs 0..P-1 and `phase1` is high exactly when c < floor(P/2).
- R3: `rstGate` is high exactly when the block is running and c < latched reset width. A width of 0 gives no pulse, and a width of P or more covers the whole period and ends with it.
- R4: `clampGate` is high exactly when the block is running and offset <= c < offset + latched clamp width. The pulse is clipped at the period end, and a width of 0 gives no pulse.
- R5: `periodStart` is high for exactly the one cycle with c = 0 of every running period.
- R6: The four configuration inputs are sampled only at the clock edge that begins a period. Changing them during a period has no effect on the outputs until the next period.
- R7: `muteReq` is sampled only at the edge that ends a period (c = P-1). If it is high there, `muted` is high from the next cycle. A request that is raised and dropped again before that edge has no effect.
- R8: While `muted` is high: `phase1` = 1, `phase2` = 0, `rstGate` = 0, `clampGate` = 0, `periodStart` = 0.
- R9: While muted, if `muteReq` is low at an edge, the next cycle is running, with c = 0, `periodStart` high and freshly sampled configuration.
- R10: During and right after reset the block is muted, with the R8 output levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgPeriod | input | CNT_W | Phase period in master cycles |
| cfgRstWidth | input | CNT_W | Reset pulse width in master cycles |
| cfgClampWidth | input | CNT_W | Clamp pulse width in master cycles |
| cfgClampOffset | input | CNT_W | Clamp start offset from the reset start, in master cycles |
| muteReq | input | 1 | Request from the sequencer to stop the clocks |
| phase1 | output | 1 | Transfer phase 1 |
| phase2 | output | 1 | Transfer phase 2, the complement of phase 1 |
| rstGate | output | 1 | Reset gate pulse |
| clampGate | output | 1 | Clamp pulse |
| periodStart | output | 1 | Strobe in the first cycle of each period |
| muted | output | 1 | Clocks frozen (acknowledge of muteReq) |

## Verification
The bench covers:
- **Odd periods and the period-2 floor.** A wrong half-period split would show up as an asymmetric `phase1` duty.
- **Over-long reset and clamp settings.** A generator without clipping would carry a pulse into the next period or wrap its counter.
- **Configuration changes in the middle of a period.** Loading the new values at once would give a truncated or stretched pulse.
- **Mute requests at arbitrary points, including single-cycle blips.** A block that muted immediately would freeze a phase mid-period.
- **Release from mute.** A release that resumed the old count would be caught by the missing `periodStart`.

// File: rtl/ccd_clk_pkg.sv
package ccd_clk_pkg;
  // Strobes from the sequencing control to the counting datapath
  typedef struct packed {
    logic restart;   // begin a new period: count to zero, sample configuration
    logic advance;   // step the count
    logic active;    // clocks running (not muted)
  } seqStrobes_t;

  localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/ccd_clk_ctrl.sv
module ccd_clk_ctrl
  import ccd_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        muteReq,
  input  logic        atEnd,
  output seqStrobes_t strobes,
  output logic        muted
);
  logic mutedNext;

  always_comb begin
    strobes.restart = 1'b0;
    strobes.advance = 1'b0;
    strobes.active  = ~muted;
    mutedNext       = muted;
    if (muted) begin
      if (!muteReq) begin
        strobes.restart = 1'b1;
        mutedNext       = 1'b0;
      end
    end else if (atEnd) begin
      if (muteReq) mutedNext = 1'b1;   // R7: stop only at the boundary
      else         strobes.restart = 1'b1;
    end else begin
      strobes.advance = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) muted <= 1'b1;         // R10
    else        muted <= mutedNext;
  end
endmodule

// File: rtl/ccd_clk_datapath.sv
module ccd_clk_datapath
  import ccd_clk_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobes_t      strobes,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgRstWidth,
  input  logic [CNT_W-1:0] cfgClampWidth,
  input  logic [CNT_W-1:0] cfgClampOffset,
  output logic             phase1,
  output logic             rstGate,
  output logic             clampGate,
  output logic             periodStart,
  output logic             atEnd
);
  localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perLat;
  logic [CNT_W-1:0] rstLat;
  logic [CNT_W-1:0] clWidthLat;
  logic [CNT_W-1:0] clOffLat;
  logic [CNT_W-1:0] perSel;
  logic [CNT_W-1:0] halfPer;
  logic [CNT_W:0]   clampEnd;

  assign perSel = (cfgPeriod < PER_FLOOR) ? PER_FLOOR : cfgPeriod;

  // R6: configuration sampled only when a period begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      perLat     <= PER_FLOOR;
      rstLat     <= '0;
      clWidthLat <= '0;
      clOffLat   <= '0;
    end else if (strobes.restart) begin
      cnt        <= '0;
      perLat     <= perSel;
      rstLat     <= cfgRstWidth;
      clWidthLat <= cfgClampWidth;
      clOffLat   <= cfgClampOffset;
    end else if (strobes.advance) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign atEnd    = (cnt == perLat - 1'b1);
  assign halfPer  = perLat >> 1;
  assign clampEnd = {1'b0, clOffLat} + {1'b0, clWidthLat};

  // Pulses decode from the count, which never passes perLat-1: clipping is free
  assign phase1      = ~strobes.active | (cnt < halfPer);
  assign rstGate     = strobes.active & (cnt < rstLat);
  assign clampGate   = strobes.active & (cnt >= clOffLat) & ({1'b0, cnt} < clampEnd);
  assign periodStart = strobes.active & (cnt == '0);
endmodule

// File: rtl/ccd_readout_clkgen.sv
module ccd_readout_clkgen
  import ccd_clk_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgRstWidth,
  input  logic [CNT_W-1:0] cfgClampWidth,
  input  logic [CNT_W-1:0] cfgClampOffset,
  input  logic             muteReq,
  output logic             phase1,
  output logic             phase2,
  output logic             rstGate,
  output logic             clampGate,
  output logic             periodStart,
  output logic             muted
);
  seqStrobes_t strobes;
  logic        atEnd;

  ccd_clk_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .muteReq (muteReq),
    .atEnd   (atEnd),
    .strobes (strobes),
    .muted   (muted)
  );

  ccd_clk_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .cfgPeriod      (cfgPeriod),
    .cfgRstWidth    (cfgRstWidth),
    .cfgClampWidth  (cfgClampWidth),
    .cfgClampOffset (cfgClampOffset),
    .phase1         (phase1),
    .rstGate        (rstGate),
    .clampGate      (clampGate),
    .periodStart    (periodStart),
    .atEnd          (atEnd)
  );

  assign phase2 = ~phase1;   // R1
endmodule

// File: rtl/ccd_readout_clkgen_chk.sv
module ccd_readout_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic muteReq,
  input logic phase1,
  input logic phase2,
  input logic rstGate,
  input logic clampGate,
  input logic periodStart,
  input logic muted
);
  // R5: a period lasts at least two cycles, so the strobe never repeats back to back
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    periodStart |=> !periodStart);

  // R7: muting begins only after a sampled request
  a_r7_mute_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(muted) |-> $past(muteReq));

  // R8: frozen levels while muted
  a_r8_muted_levels: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> (phase1 && !phase2 && !rstGate && !clampGate && !periodStart));

  // R9: release always begins a fresh period
  a_r9_release_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(muted) |-> periodStart);

  // R2: the first cycle of a period lies in the phase-1 high half
  a_r2_start_phase_high: assert property (@(posedge clk) disable iff (!rst_n)
    periodStart |-> (phase1 && !phase2));
endmodule

bind ccd_readout_clkgen ccd_readout_clkgen_chk u_chk (.*);

// File: tb/ccd_readout_clkgen_bench.sv
module ccd_readout_clkgen_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfgPeriod = 8'd10;
  logic [CNT_W-1:0] cfgRstWidth = 8'd3;
  logic [CNT_W-1:0] cfgClampWidth = 8'd4;
  logic [CNT_W-1:0] cfgClampOffset = 8'd2;
  logic             muteReq = 1'b0;
  logic phase1, phase2, rstGate, clampGate, periodStart, muted;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string focus = "R2";

  always #4 clk = ~clk;   // 125 MHz

  ccd_readout_clkgen #(.CNT_W(CNT_W)) u_ccd_readout_clkgen (
    .clk(clk), .rst_n(rst_n),
    .cfgPeriod(cfgPeriod), .cfgRstWidth(cfgRstWidth),
    .cfgClampWidth(cfgClampWidth), .cfgClampOffset(cfgClampOffset),
    .muteReq(muteReq),
    .phase1(phase1), .phase2(phase2), .rstGate(rstGate),
    .clampGate(clampGate), .periodStart(periodStart), .muted(muted)
  );

  typedef struct packed {
    logic p1, rg, cg, ps, mu, rel;
  } expItem_t;
  expItem_t expQ[$];

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) t=%0t actual=%b expected=%b", req, focus, $time, act, exp);
    end
  endtask

  // Reference model built from the requirements
  int mCnt = 0, mP = 2, mW = 0, mCw = 0, mOff = 0;
  bit mMuted = 1'b1;
  always @(posedge clk) begin
    bit rel;
    expItem_t it;
    if (rst_n) begin
      rel = 1'b0;
      if (mMuted) begin
        if (!muteReq) begin
          mMuted = 1'b0; mCnt = 0; rel = 1'b1;
          mP = (cfgPeriod < 2) ? 2 : int'(cfgPeriod);
          mW = cfgRstWidth; mCw = cfgClampWidth; mOff = cfgClampOffset;
        end
      end else if (mCnt == mP - 1) begin
        if (muteReq) mMuted = 1'b1;
        else begin
          mCnt = 0;
          mP = (cfgPeriod < 2) ? 2 : int'(cfgPeriod);
          mW = cfgRstWidth; mCw = cfgClampWidth; mOff = cfgClampOffset;
        end
      end else mCnt++;
      it.mu  = mMuted;
      it.p1  = mMuted ? 1'b1 : (mCnt < mP / 2);
      it.rg  = !mMuted && (mCnt < mW);
      it.cg  = !mMuted && (mCnt >= mOff) && (mCnt < mOff + mCw);
      it.ps  = !mMuted && (mCnt == 0);
      it.rel = rel;
      expQ.push_back(it);
    end
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    expItem_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      chk(e.mu ? "R8" : "R2", phase1, e.p1);
      chk("R1", phase2, ~phase1);
      chk(e.mu ? "R8" : "R3", rstGate, e.rg);
      chk(e.mu ? "R8" : "R4", clampGate, e.cg);
      chk(e.rel ? "R9" : "R5", periodStart, e.ps);
      chk("R7", muted, e.mu);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input int p, input int w, input int off, input int cw);
    cfgPeriod = CNT_W'(p); cfgRstWidth = CNT_W'(w);
    cfgClampOffset = CNT_W'(off); cfgClampWidth = CNT_W'(cw);
  endtask

  task automatic waitStart();
    @(negedge clk);
    while (!periodStart) @(negedge clk);
  endtask

  initial begin
    // R10: reset state
    focus = "R10";
    muteReq = 1'b1;
    cycles(2);
    chk("R10", muted, 1'b1);
    chk("R10", phase1, 1'b1);
    chk("R10", phase2, 1'b0);
    chk("R10", rstGate | clampGate | periodStart, 1'b0);
    rst_n = 1'b1;
    cycles(3);
    chk("R10", muted, 1'b1);

    focus = "R9"; muteReq = 1'b0;
    setCfg(10, 3, 2, 4);
    cycles(40);

    focus = "R3"; setCfg(7, 9, 5, 6);   // odd period, over-long reset and clamp
    cycles(30);
    focus = "R4"; setCfg(9, 0, 3, 0);   // zero widths
    cycles(25);
    focus = "R2"; setCfg(1, 1, 1, 5);   // period floor of 2
    cycles(12);
    setCfg(0, 2, 0, 1);
    cycles(8);

    focus = "R6"; setCfg(12, 2, 1, 3);
    waitStart(); cycles(3);
    setCfg(6, 5, 0, 2);                 // mid-period change
    cycles(40);

    focus = "R7"; setCfg(10, 3, 4, 3);
    waitStart(); cycles(2);
    muteReq = 1'b1; cycles(25);
    focus = "R9"; muteReq = 1'b0; cycles(30);

    focus = "R7";                       // short blips inside a period
    for (int k = 0; k < 8; k++) begin
      cycles(3 + k);
      muteReq = 1'b1; cycles(1); muteReq = 1'b0;
      cycles(2);
    end
    cycles(30);
    focus = "R8"; muteReq = 1'b1; cycles(30);
    focus = "R9"; setCfg(5, 2, 1, 2); muteReq = 1'b0; cycles(30);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (%s) actual=hung expected=done", focus);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule